// File: doc/BRIEF.md
# Phase-Reversal Coincident-Current Line Decoder

This block turns a word address and the state of the access cycle into one-hot drive-line selects for a magnetic-core array. The array is selected by coincident half-currents.

The X part of the address is decoded in two levels. One decoder picks a gate line and another picks a driver. The gate line and the driver meet in 4-by-8 select cards, and one X wire is energized where they cross. The Y part of the address picks one Y wire. A separate reversal bit sets the polarity of the Y current.

Each physical X wire runs through two row segments in opposite senses. With a given Y wire, two cores see both currents, but the currents add in only one of them. The Y polarity decides which one, so 128 X drivers reach 256 rows. A behavioural coincidence model inside the block computes which core receives adding currents. It reports the row and the column of that core.

The block also reports the current direction for the read half or the write half. It enables one array in half-word mode and both arrays in full-word mode. All outputs come from registers: the decode of the inputs presented on one clock edge appears after that edge.

Top module: `core_line_decoder`

## Requirements
- R1: Address fields are fixed. addr_i[6:0] is the X address, addr_i[13:7] is the Y address and addr_i[14] is the reversal bit. The outputs show the decode of the inputs sampled at the previous rising clock edge.
- R2: During an active half, x_gate_o is one-hot at bit addr_i[6:3] and x_drv_o is one-hot at bit addr_i[2:0].
- R3: During an active half, exactly one bit of x_line_o is set, at index gate*8+driver (equal to addr_i[6:0]). A line is set only when its card's row input and column input are both active.
- R4: During an active half, y_line_o is one-hot at bit addr_i[13:7].
- R5: During an active half, y_rev_o equals addr_i[14].
- R6: The coincidence model marks exactly one core during an active half. Its row is addr_i[6:0] when the reversal bit is 0 and 128+addr_i[6:0] when it is 1. Its column is addr_i[13:7], and core_hit_o is 1.
- R7: dir_wr_o is 1 in a write half and 0 in a read half. When rd_half_i and wr_half_i are both high, the read half wins.
- R8: Outside an active half, every select output, y_rev_o, dir_wr_o, core_hit_o, core_row_o and core_col_o is zero.
- R9: In half-word mode (half_word_i=1), arr_en_o is 2'b01 when arr_sel_i=0 and 2'b10 when arr_sel_i=1. The arr_sel_i input has no effect in full-word mode.
- R10: In full-word mode during an active half, arr_en_o is 2'b11.
- R11: While rst_ni is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_half_i | input | 1 | Read half of the cycle is active |
| wr_half_i | input | 1 | Write half of the cycle is active |
| addr_i | input | 15 | Word address: X, Y and reversal bit |
| half_word_i | input | 1 | 1 selects half-word mode (one array) |
| arr_sel_i | input | 1 | Array choice in half-word mode |
| x_gate_o | output | 16 | One-hot gate line select |
| x_drv_o | output | 8 | One-hot X driver select |
| x_line_o | output | 128 | One-hot X drive wire |
| y_line_o | output | 128 | One-hot Y drive wire |
| y_rev_o | output | 1 | Y current reversed (segment B) |
| dir_wr_o | output | 1 | Current in write direction |
| arr_en_o | output | 2 | Array drive enables |
| core_hit_o | output | 1 | A core receives adding currents |
| core_row_o | output | 8 | Physical row of the selected core |
| core_col_o | output | 7 | Column of the selected core |

## Verification
The assertions check several properties on every cycle. An active half energizes exactly one X wire and one Y wire. Each card line needs both its row input and its column input. The coincidence model never marks more than one core, and it marks one whenever both wires are driven. Idle cycles leave every select zero, half-word mode enables a single array, and a write half sets the write direction. Only the bench scenarios can show that the right wire, core row and array are chosen for a given address and mode. That includes the segment B row offset, the read-over-write precedence and arr_sel_i having no effect in full-word mode.

// File: rtl/core_line_pkg.sv
package core_line_pkg;
  localparam int unsigned GATE_W_D = 4;
  localparam int unsigned DRV_W_D  = 3;
  localparam int unsigned Y_W_D    = 7;
  localparam int unsigned CARD_ROWS = 4;
  localparam int unsigned N_ARR     = 2;

  typedef enum logic [1:0] {
    HALF_IDLE  = 2'b00,
    HALF_READ  = 2'b01,
    HALF_WRITE = 2'b10
  } half_e;
endpackage

// File: rtl/onehot_dec.sv
module onehot_dec #(
  parameter int unsigned W = 3,
  localparam int unsigned N = 2 ** W
) (
  input  logic         en_i,
  input  logic [W-1:0] idx_i,
  output logic [N-1:0] sel_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign sel_o[i] = en_i && (idx_i == W'(i));
  end
endmodule

// File: rtl/gate_card.sv
module gate_card #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 8,
  localparam int unsigned N = ROWS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ROWS-1:0] row_i,
  input  logic [COLS-1:0] col_i,
  output logic [N-1:0]    line_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign line_o[r*COLS+c] = row_i[r] & col_i[c];
    end
  end

  AST_CARD_COINCIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|line_o) |-> ((|row_i) && (|col_i))); // R3
endmodule

// File: rtl/coincidence_model.sv
module coincidence_model #(
  parameter int unsigned X_W = 7,
  parameter int unsigned Y_W = 7,
  localparam int unsigned NX = 2 ** X_W,
  localparam int unsigned NY = 2 ** Y_W,
  localparam int unsigned NROW = 2 * NX
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NX-1:0]   x_line_i,
  input  logic [NY-1:0]   y_line_i,
  input  logic            y_rev_i,
  output logic            hit_o,
  output logic [X_W:0]    row_o,
  output logic [Y_W-1:0]  col_o
);
  logic [NROW-1:0] row_hit;
  logic            y_any;

  assign y_any = |y_line_i;

  // segment A: wire runs forward, adds with normal Y; segment B: wire reversed
  for (genvar r = 0; r < NROW; r++) begin : g_row
    if (r < NX) begin : g_seg_a
      assign row_hit[r] = x_line_i[r] & y_any & ~y_rev_i;
    end else begin : g_seg_b
      assign row_hit[r] = x_line_i[r-NX] & y_any & y_rev_i;
    end
  end

  always_comb begin
    row_o = '0;
    for (int i = 0; i < NROW; i++)
      if (row_hit[i]) row_o = (X_W+1)'(i);
  end

  always_comb begin
    col_o = '0;
    for (int i = 0; i < NY; i++)
      if (y_line_i[i]) col_o = Y_W'(i);
  end

  assign hit_o = |row_hit;

  AST_SINGLE_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_hit)); // R6
  AST_DRIVE_GIVES_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|x_line_i) && y_any) |-> hit_o); // R6
endmodule

// File: rtl/core_line_decoder.sv
module core_line_decoder
  import core_line_pkg::*;
#(
  parameter int unsigned GATE_W = GATE_W_D,
  parameter int unsigned DRV_W  = DRV_W_D,
  parameter int unsigned Y_W    = Y_W_D,
  localparam int unsigned X_W    = GATE_W + DRV_W,
  localparam int unsigned ADDR_W = X_W + Y_W + 1,
  localparam int unsigned NGATE  = 2 ** GATE_W,
  localparam int unsigned NDRV   = 2 ** DRV_W,
  localparam int unsigned NX     = 2 ** X_W,
  localparam int unsigned NY     = 2 ** Y_W,
  localparam int unsigned NCARD  = NGATE / CARD_ROWS,
  localparam int unsigned CARD_N = CARD_ROWS * NDRV
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_half_i,
  input  logic              wr_half_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              half_word_i,
  input  logic              arr_sel_i,
  output logic [NGATE-1:0]  x_gate_o,
  output logic [NDRV-1:0]   x_drv_o,
  output logic [NX-1:0]     x_line_o,
  output logic [NY-1:0]     y_line_o,
  output logic              y_rev_o,
  output logic              dir_wr_o,
  output logic [N_ARR-1:0]  arr_en_o,
  output logic              core_hit_o,
  output logic [X_W:0]      core_row_o,
  output logic [Y_W-1:0]    core_col_o
);
  half_e              half_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               half_word_q;
  logic               arr_sel_q;
  logic               active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q      <= HALF_IDLE;
      addr_q      <= '0;
      half_word_q <= 1'b0;
      arr_sel_q   <= 1'b0;
    end else begin
      if (rd_half_i)      half_q <= HALF_READ;
      else if (wr_half_i) half_q <= HALF_WRITE;
      else                half_q <= HALF_IDLE;
      addr_q      <= addr_i;
      half_word_q <= half_word_i;
      arr_sel_q   <= arr_sel_i;
    end
  end

  assign active   = (half_q != HALF_IDLE);
  assign dir_wr_o = (half_q == HALF_WRITE);
  assign y_rev_o  = active & addr_q[ADDR_W-1];

  onehot_dec #(.W(GATE_W)) u_gate_dec (
    .en_i (active),
    .idx_i(addr_q[X_W-1:DRV_W]),
    .sel_o(x_gate_o)
  );

  onehot_dec #(.W(DRV_W)) u_drv_dec (
    .en_i (active),
    .idx_i(addr_q[DRV_W-1:0]),
    .sel_o(x_drv_o)
  );

  onehot_dec #(.W(Y_W)) u_y_dec (
    .en_i (active),
    .idx_i(addr_q[X_W+Y_W-1:X_W]),
    .sel_o(y_line_o)
  );

  for (genvar c = 0; c < NCARD; c++) begin : g_card
    gate_card #(.ROWS(CARD_ROWS), .COLS(NDRV)) u_card (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .row_i (x_gate_o[c*CARD_ROWS +: CARD_ROWS]),
      .col_i (x_drv_o),
      .line_o(x_line_o[c*CARD_N +: CARD_N])
    );
  end

  always_comb begin
    arr_en_o = '0;
    if (active) begin
      if (half_word_q) arr_en_o[arr_sel_q] = 1'b1;
      else             arr_en_o = '1;
    end
  end

  coincidence_model #(.X_W(X_W), .Y_W(Y_W)) u_model (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .x_line_i(x_line_o),
    .y_line_i(y_line_o),
    .y_rev_i (y_rev_o),
    .hit_o   (core_hit_o),
    .row_o   (core_row_o),
    .col_o   (core_col_o)
  );

  AST_X_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_half_i || wr_half_i) |-> ($countones(x_line_o) == 1)); // R3
  AST_Y_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_half_i || wr_half_i) |-> ($countones(y_line_o) == 1)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_half_i || wr_half_i) |->
      (x_line_o == '0 && y_line_o == '0 && arr_en_o == '0 && !core_hit_o)); // R8
  AST_WRITE_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_half_i && !rd_half_i) |-> dir_wr_o); // R7
  AST_HALF_ONE_ARRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past((rd_half_i || wr_half_i) && half_word_i) |-> ($countones(arr_en_o) == 1)); // R9
endmodule

// File: tb/core_line_decoder_tb.sv
module core_line_decoder_tb;
  typedef struct {
    logic [15:0]  xg;
    logic [7:0]   xd;
    logic [127:0] xl;
    logic [127:0] yl;
    logic         rev;
    logic         dir;
    logic [1:0]   arr;
    logic         hit;
    logic [7:0]   row;
    logic [6:0]   col;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd = 1'b0, wr = 1'b0, hw = 1'b0, sel = 1'b0;
  logic [14:0]  addr = '0;
  logic [15:0]  x_gate;
  logic [7:0]   x_drv;
  logic [127:0] x_line, y_line;
  logic         y_rev, dir_wr, hit;
  logic [1:0]   arr_en;
  logic [7:0]   row;
  logic [6:0]   col;

  int n_tests = 0;
  int n_fail  = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  core_line_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_half_i(rd), .wr_half_i(wr),
    .addr_i(addr), .half_word_i(hw), .arr_sel_i(sel),
    .x_gate_o(x_gate), .x_drv_o(x_drv), .x_line_o(x_line), .y_line_o(y_line),
    .y_rev_o(y_rev), .dir_wr_o(dir_wr), .arr_en_o(arr_en),
    .core_hit_o(hit), .core_row_o(row), .core_col_o(col)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic w, input logic h, input logic s, input logic [14:0] a);
    exp_t e;
    logic act;
    @(negedge clk);
    rd = r; wr = w; hw = h; sel = s; addr = a;
    act   = r | w;
    e.xg  = act ? (16'd1 << a[6:3]) : '0;
    e.xd  = act ? (8'd1 << a[2:0]) : '0;
    e.xl  = act ? (128'd1 << a[6:0]) : '0;
    e.yl  = act ? (128'd1 << a[13:7]) : '0;
    e.rev = act & a[14];
    e.dir = w & ~r;
    e.arr = !act ? 2'b00 : (h ? (s ? 2'b10 : 2'b01) : 2'b11);
    e.hit = act;
    e.row = act ? {a[14], a[6:0]} : '0;
    e.col = act ? a[13:7] : '0;
    q.push_back(e);
  endtask

  // monitor: compare what the previous negedge pushed, two ns after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(x_gate == e.xg, "R2 gate", 128'(x_gate), 128'(e.xg));
        chk(x_drv  == e.xd, "R2 drv",  128'(x_drv),  128'(e.xd));
        chk(x_line == e.xl, "R3 xline", x_line, e.xl);
        chk(y_line == e.yl, "R4 yline", y_line, e.yl);
        chk(y_rev  == e.rev, "R5 yrev", 128'(y_rev), 128'(e.rev));
        chk(dir_wr == e.dir, "R7 dir",  128'(dir_wr), 128'(e.dir));
        chk(arr_en == e.arr, "R9/R10 arr", 128'(arr_en), 128'(e.arr));
        chk(hit    == e.hit, "R6 hit",  128'(hit), 128'(e.hit));
        chk(row    == e.row, "R6 row",  128'(row), 128'(e.row));
        chk(col    == e.col, "R6 col",  128'(col), 128'(e.col));
      end
    end
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [14:0] lf;
    #23;
    // R11: reset state
    chk(x_line == '0 && y_line == '0 && x_gate == '0 && x_drv == '0, "R11 lines", x_line | y_line, '0);
    chk({y_rev, dir_wr, arr_en, hit, row, col} == '0, "R11 misc", 128'({y_rev, dir_wr, arr_en, hit, row, col}), '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1/R8: idle cycle then corners
    drive(0, 0, 0, 0, 15'h7fff);                 // R8 idle with full address
    drive(1, 0, 0, 0, 15'h0000);                 // R1 lowest address, read
    drive(0, 1, 0, 0, 15'h7fff);                 // R6 segment B top core, write
    drive(1, 0, 0, 0, 15'h3fff);                 // R5 reversal 0, all else ones
    drive(0, 1, 0, 0, 15'h4000);                 // R6 row 128
    drive(1, 1, 0, 0, 15'h1234);                 // R7 read wins
    drive(0, 0, 1, 1, 15'h5555);                 // R8 idle in half-word
    drive(1, 0, 1, 0, 15'h2a5a);                 // R9 array 0
    drive(0, 1, 1, 1, 15'h2a5a);                 // R9 array 1
    drive(1, 0, 0, 1, 15'h0f0f);                 // R9 sel ignored in full-word, R10
    drive(0, 1, 0, 0, 15'h0080);                 // R4 y=1, x=0
    drive(1, 0, 0, 0, 15'h007f);                 // R3 last card last line
    drive(1, 0, 0, 0, 15'h0020);                 // R3 second card first line
    lf = 15'h1ace;
    for (int i = 0; i < 40; i++) begin
      lf = {lf[13:0], lf[14] ^ lf[13]};
      drive(lf[0], lf[1], lf[2], lf[3], lf);
    end
    drive(0, 0, 0, 0, 15'h0000);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule